// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block selects the single most urgent pending interrupt of a 16550-style serial port. From that choice it builds the identification byte that software reads, and it drives one level-sensitive interrupt line. The block receives the enable bits and the raw status conditions from the rest of the port: line errors, data-ready, the receive FIFO count and trigger level, character timeout and modem-status deltas. It holds the transmitter-empty pending flag itself, because that source is set and cleared by events and not by a status level.

Five sources are ranked in a fixed order. Each source reports its own code in the low nibble of the identification byte. The code is registered on every clock from the inputs sampled on that clock, so the interrupt line comes straight from a flop and holds steady during bus reads. The upper nibble shows whether the FIFOs are enabled. When software reads the identification byte while it reports transmitter-empty, the pending flag behind that source is cleared.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is active and on the first cycle after it, `iir_out` is 0x01 and `irq` is low.
- R2: Line-status source: enable bit 2 is set and any bit of `lsr_err` is set. One cycle later the low nibble is 0x6. This source outranks all other sources.
- R3: Timeout source: enable bit 0 is set and `rx_timeout` is high, with no line-status source active. One cycle later the low nibble is 0xC. This source outranks received data.
- R4: Received-data source: enable bit 0 is set and `data_ready` is high. With `fifo_en` high it also needs `rx_count >= rx_trig`; with `fifo_en` low, `data_ready` alone is enough. The source then gives low nibble 0x4.
- R5: Transmitter-empty source: enable bit 1 is set and the pending flag is set. It gives low nibble 0x2 and outranks the modem source.
- R6: Modem source: enable bit 3 is set and any bit of `msr_delta` is set. With no other source active, it gives low nibble 0x0.
- R7: The upper nibble of `iir_out` is 0xC one cycle after `fifo_en` is high and 0x0 one cycle after it is low.
- R8: `irq` is high exactly when the low nibble of `iir_out` is not 0x1.
- R9: A pulse on `iir_rd` while the low nibble reads 0x2 clears the pending flag, so 0x2 disappears two cycles later. A read that sees any other code leaves the flag set.
- R10: When enable bit 1 goes from 0 to 1 while `thr_empty` is high, the pending flag is set. When that bit goes from 1 to 0, the flag is cleared.
- R11: A pulse on `thr_empty_set` sets the pending flag. A pulse on `thr_write` clears it, and wins over every setting event in the same cycle.
- R12: A source whose enable bit is clear never raises `irq`, even if its condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier | input | 4 | Enables: bit0 rx/timeout, bit1 tx-empty, bit2 line status, bit3 modem |
| lsr_err | input | 4 | Line error flags (overrun, parity, framing, break) |
| data_ready | input | 1 | Receive data available |
| fifo_en | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_empty_set | input | 1 | Pulse: holding register has just become empty |
| thr_write | input | 1 | Pulse: holding register written |
| msr_delta | input | 4 | Modem status change bits |
| iir_rd | input | 1 | Pulse: identification byte read |
| iir_out | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle the assertions check several things. A line-status or modem condition seen on one clock must show up as its code on the next. `irq` must agree with the code. Reset must leave 0x01. A read that sees 0x2, or a dropped enable bit, must clear the pending flag. Only the directed scenarios can show the full ranking across several sources at once, and the trigger-level threshold at the exact count. They also show that a read reporting some other code leaves the flag alone, and that the flag does not set again when the enable bit rises while the holding register is full.

// File: rtl/uart_irq_pkg.sv
// Shared codes and enable-bit positions for the interrupt identifier.
// Assumes a 4-bit low-nibble identification code as read by software.
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IC_MODEM = 4'h0,
        IC_NONE  = 4'h1,
        IC_THR   = 4'h2,
        IC_RXD   = 4'h4,
        IC_LINE  = 4'h6,
        IC_TMO   = 4'hC
    } irq_code_e;

    localparam int EN_RX    = 0;
    localparam int EN_THR   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    localparam int NUM_SRC  = 5;

    // Code for a source index, index 0 being the most urgent.
    function automatic irq_code_e src_code(input int idx);
        case (idx)
            0:       return IC_LINE;
            1:       return IC_TMO;
            2:       return IC_RXD;
            3:       return IC_THR;
            default: return IC_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_req.sv
// Builds one request bit per interrupt source from enables and status.
// Index 0 is the most urgent source. Purely combinational; it assumes the
// transmitter-empty pending flag comes in already registered.
module uart_irq_req
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]         ier,
    input  logic [3:0]         lsr_err,
    input  logic               data_ready,
    input  logic               fifo_en,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   rx_trig,
    input  logic               rx_timeout,
    input  logic               thr_pend,
    input  logic [3:0]         msr_delta,
    output logic [NUM_SRC-1:0] req
);

    logic rx_level_ok;

    // Received data qualifies on the trigger level only when FIFOs are on.
    always_comb rx_level_ok = !fifo_en || (rx_count >= rx_trig);

    // One request per source, gated by its enable bit.
    always_comb begin
        req[0] = ier[EN_LINE]  && (|lsr_err);
        req[1] = ier[EN_RX]    && rx_timeout;
        req[2] = ier[EN_RX]    && data_ready && rx_level_ok;
        req[3] = ier[EN_THR]   && thr_pend;
        req[4] = ier[EN_MODEM] && (|msr_delta);
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: the lowest set request index wins and gives
// its identification code. With no request set, the code is "none".
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output irq_code_e          code
);

    // Walk from least to most urgent so that the most urgent source wins.
    always_comb begin
        code = IC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) code = src_code(i);
        end
    end

endmodule

// File: rtl/uart_irq_thre_flag.sv
// Holds the transmitter-empty pending flag. Events that apply in the
// same cycle take effect in this order, the later one winning: enable
// rise (when empty), enable fall, empty pulse, identification read
// reporting tx-empty, holding write.
module uart_irq_thre_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_en,
    input  logic thr_empty,
    input  logic thr_empty_set,
    input  logic thr_write,
    input  logic rd_clear,
    output logic pend
);

    logic en_q;

    // Remember the previous enable value to find its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= thr_en;
    end

    // Update the pending flag from the ordered event list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            logic nxt;
            nxt = pend;
            if (thr_en && !en_q && thr_empty) nxt = 1'b1;
            if (!thr_en && en_q)              nxt = 1'b0;
            if (thr_empty_set)                nxt = 1'b1;
            if (rd_clear)                     nxt = 1'b0;
            if (thr_write)                    nxt = 1'b0;
            pend <= nxt;
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identifier. It registers the winning code and the
// FIFO-enable nibble every clock, so irq comes straight from a flop.
// Assumes all inputs are synchronous to clk and that the strobes are
// single-cycle pulses.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier,
    input  logic [3:0]       lsr_err,
    input  logic             data_ready,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             thr_empty_set,
    input  logic             thr_write,
    input  logic [3:0]       msr_delta,
    input  logic             iir_rd,
    output logic [7:0]       iir_out,
    output logic             irq
);

    localparam logic [3:0] FIFO_NIB = 4'hC;

    logic [NUM_SRC-1:0] req;
    irq_code_e          code_d;
    irq_code_e          code_q;
    logic               fifo_q;
    logic               thr_pend;
    logic               rd_clear;

    // A read clears the tx-empty flag only if it sees that code.
    always_comb rd_clear = iir_rd && (code_q == IC_THR);

    uart_irq_thre_flag u_thre (
        .clk           (clk),
        .rst_n         (rst_n),
        .thr_en        (ier[EN_THR]),
        .thr_empty     (thr_empty),
        .thr_empty_set (thr_empty_set),
        .thr_write     (thr_write),
        .rd_clear      (rd_clear),
        .pend          (thr_pend)
    );

    uart_irq_req #(.CNT_W(CNT_W)) u_req (
        .ier        (ier),
        .lsr_err    (lsr_err),
        .data_ready (data_ready),
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .thr_pend   (thr_pend),
        .msr_delta  (msr_delta),
        .req        (req)
    );

    uart_irq_prio u_prio (
        .req  (req),
        .code (code_d)
    );

    // Register the code and the FIFO indication every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= IC_NONE;
            fifo_q <= 1'b0;
        end else begin
            code_q <= code_d;
            fifo_q <= fifo_en;
        end
    end

    // Assemble the identification byte and the request line from flops.
    always_comb begin
        iir_out = {(fifo_q ? FIFO_NIB : 4'h0), code_q};
        irq     = (code_q != IC_NONE);
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker bound to the identifier. It relates the inputs of one cycle
// to the registered outputs of the next, and watches the pending flag.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier,
    input logic [3:0] lsr_err,
    input logic       rx_timeout,
    input logic [3:0] msr_delta,
    input logic       thr_empty_set,
    input logic       iir_rd,
    input logic [7:0] iir_out,
    input logic       irq,
    input logic       thr_pend
);

    // R1: reset leaves no interrupt on the next cycle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (iir_out == 8'h01 && !irq));

    // R2: an enabled line error wins on the next cycle.
    assert_line_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[2] && |lsr_err) |=> (iir_out[3:0] == 4'h6));

    // R3: an enabled timeout wins when no line error is active.
    assert_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[0] && rx_timeout && !(ier[2] && |lsr_err)) |=> (iir_out[3:0] == 4'hC));

    // R8: irq agrees with the reported code.
    assert_irq_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_out[3:0] != 4'h1));

    // R9: a read that sees tx-empty clears the flag.
    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_out[3:0] == 4'h2 && !thr_empty_set) |=> !thr_pend);

    // R10: dropping the enable clears the flag.
    assert_en_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ier[1]) && !thr_empty_set) |=> !thr_pend);

    // R12: with every enable off, no interrupt appears on the next cycle.
    assert_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'h0 && !$isunknown(ier)) |=> !irq);

    // R6: lone modem change reports code 0.
    assert_modem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'b1000 && |msr_delta) |=> (iir_out[3:0] == 4'h0 && irq));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ier           (ier),
    .lsr_err       (lsr_err),
    .rx_timeout    (rx_timeout),
    .msr_delta     (msr_delta),
    .thr_empty_set (thr_empty_set),
    .iir_rd        (iir_rd),
    .iir_out       (iir_out),
    .irq           (irq),
    .thr_pend      (thr_pend)
);

// File: tb/uart_irq_ident_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_irq_ident_tb;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       ier = '0;
    logic [3:0]       lsr_err = '0;
    logic             data_ready = 1'b0;
    logic             fifo_en = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_trig = '0;
    logic             rx_timeout = 1'b0;
    logic             thr_empty = 1'b0;
    logic             thr_empty_set = 1'b0;
    logic             thr_write = 1'b0;
    logic [3:0]       msr_delta = '0;
    logic             iir_rd = 1'b0;
    logic [7:0]       iir_out;
    logic             irq;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_err(lsr_err),
        .data_ready(data_ready), .fifo_en(fifo_en), .rx_count(rx_count),
        .rx_trig(rx_trig), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
        .thr_empty_set(thr_empty_set), .thr_write(thr_write),
        .msr_delta(msr_delta), .iir_rd(iir_rd), .iir_out(iir_out), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] exp_iir, input logic exp_irq);
        n_run++;
        if (iir_out !== exp_iir || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     req, iir_out, irq, exp_iir, exp_irq);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_inputs();
        ier = '0; lsr_err = '0; data_ready = 0; fifo_en = 0; rx_count = '0;
        rx_trig = '0; rx_timeout = 0; thr_empty = 0; thr_empty_set = 0;
        thr_write = 0; msr_delta = '0; iir_rd = 0;
        wait_n(3);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        wait_n(1);
        sig = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        wait_n(2);
        check("R1 in reset", 8'h01, 1'b0);
        rst_n = 1;
        wait_n(1);
        check("R1 after reset", 8'h01, 1'b0);
    endtask

    task automatic t_line();
        ier = 4'b0100; lsr_err = 4'b0010;
        wait_n(1);
        check("R2 line alone / R8", 8'h06, 1'b1);
        ier = 4'b1111; rx_timeout = 1; data_ready = 1; msr_delta = 4'h1;
        wait_n(1);
        check("R2 outranks all", 8'h06, 1'b1);
        idle_inputs();
    endtask

    task automatic t_disabled();
        ier = 4'b0000; lsr_err = 4'hF; rx_timeout = 1; data_ready = 1; msr_delta = 4'hF;
        wait_n(2);
        check("R12 disabled sources", 8'h01, 1'b0);
        idle_inputs();
    endtask

    task automatic t_timeout();
        fifo_en = 1; rx_trig = 5'd4; rx_count = 5'd8; data_ready = 1;
        rx_timeout = 1; ier = 4'b0001;
        wait_n(1);
        check("R3 timeout over rx data / R7", 8'hCC, 1'b1);
        idle_inputs();
    endtask

    task automatic t_rx();
        fifo_en = 1; rx_trig = 5'd4; rx_count = 5'd3; data_ready = 1; ier = 4'b0001;
        wait_n(1);
        check("R4 below trigger", 8'hC1, 1'b0);
        rx_count = 5'd4;
        wait_n(1);
        check("R4 at trigger", 8'hC4, 1'b1);
        fifo_en = 0; rx_count = 5'd0;
        wait_n(1);
        check("R4 no fifo, data ready / R7", 8'h04, 1'b1);
        data_ready = 0;
        wait_n(1);
        check("R4 no data", 8'h01, 1'b0);
        idle_inputs();
    endtask

    task automatic t_thr_read();
        thr_empty = 1; msr_delta = 4'h2;
        ier = 4'b1010;
        wait_n(2);
        check("R10 enable rise sets / R5 over modem", 8'h02, 1'b1);
        pulse(iir_rd);
        wait_n(1);
        check("R9 read clears / R6 modem", 8'h00, 1'b1);
        msr_delta = 4'h0;
        wait_n(1);
        check("R6 delta gone", 8'h01, 1'b0);
        idle_inputs();
    endtask

    task automatic t_thr_events();
        ier = 4'b0110; lsr_err = 4'b1000;
        wait_n(1);
        pulse(thr_empty_set);
        wait_n(1);
        check("R11 line over set flag", 8'h06, 1'b1);
        pulse(iir_rd);
        lsr_err = 4'h0;
        wait_n(2);
        check("R9 other-code read keeps flag", 8'h02, 1'b1);
        pulse(thr_write);
        wait_n(1);
        check("R11 write clears", 8'h01, 1'b0);
        pulse(thr_empty_set);
        wait_n(1);
        check("R11 empty pulse sets", 8'h02, 1'b1);
        ier = 4'b0000;
        wait_n(2);
        ier = 4'b0010; thr_empty = 0;
        wait_n(2);
        check("R10 fall clears, rise while full stays clear", 8'h01, 1'b0);
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_line();
        t_disabled();
        t_timeout();
        t_rx();
        t_thr_read();
        t_thr_events();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule